// File: doc/BRIEF.md
# Shadowed BCD Calendar Timekeeper

This block keeps wall-clock time at one-second resolution. A once-per-second pulse advances a working set of counters holding century, year, month, day of month, day of week, hours, minutes and seconds. Every field is packed BCD, and hours run from 00 to 23. Month lengths and leap years are handled inside the counters. A second, host-visible copy of the same fields sits between the counters and a small register port, which selects a field with a 4-bit index.

Two hold bits in the control byte govern that visible copy. The read hold freezes it, so a host can read all fields as one coherent snapshot while the counters keep running. The write hold stops refresh and opens the copy to host writes. Clearing the write hold moves the copy into the counters in a single cycle. A stop bit in the seconds byte halts counting altogether. Reads are combinational from the visible copy. Writes take effect at the clock edge.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the visible fields read: control 00, seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00. The counters run (stop bit 0) and both hold bits are 0.
- R2: The index map is as follows. Index 8 is control: bit 7 write hold, bit 6 read hold, bits 5:0 century. Index 9 is seconds, with the stop bit in bit 7. Then A minutes, B hours, C day of week, D date, E month, F year. Storage widths are 7 bits for seconds and minutes, 6 for hours, date and century, 3 for day of week, 5 for month and 8 for year, and unused high bits read 0. Indices 0 to 7 read 00 and writes to them change nothing.
- R3: Each pulse while running adds one second. Seconds roll 59→00 into minutes, minutes roll 59→00 into hours, and hours roll 23→00 into both date and day of week. Day of week rolls 7→1.
- R4: Date rolls back to 01 after the month's last day: 30 for months 04, 06, 09 and 11; 31 for the other months except 02; for 02, 29 when the two-digit year is divisible by 4 and 28 otherwise. Month rolls 12→01 into the year.
- R5: Year rolling 99→00 increments the century. Century rolls 39→00.
- R6: The stop bit is written through index 9 bit 7 at any time and reads back in that position. While it is 1, pulses do not change the counters.
- R7: With both hold bits 0, each pulse copies the newly advanced counters into the visible fields, readable from the next cycle.
- R8: While the read hold is 1, the visible fields keep their values and the counters keep advancing. The first pulse after the read hold clears shows the current counter value.
- R9: While the write hold is 1, pulses do not change the visible fields, and host writes to indices 8 to F load them (masked to the field width). A control write whose bit 7 is 1 loads the century as well.
- R10: A control write with bit 7 at 0 while the write hold is 1 copies the visible fields into the counters in that cycle. A pulse in that same cycle is dropped, and the next pulse advances from the loaded value.
- R11: While the write hold is 0, host writes leave the time fields and the century unchanged. Only the two hold bits and the stop bit take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register index |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data for host_addr |

## Verification
The two functions that can meet in one cycle are the seconds pulse and the hold-release transfer into the counters, along with a pulse arriving while a hold is active. The bench drives the control write that clears the write hold on the same clock edge as a pulse. It expects to read back exactly the loaded time, and one second more only after the following pulse. The read-hold case is judged by letting several pulses pass under the hold, then confirming that the first pulse after release shows the full accumulated advance.

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       host_we,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);

  localparam int CEN  = 0;
  localparam int SEC  = 1;
  localparam int MIN  = 2;
  localparam int HR   = 3;
  localparam int DOW  = 4;
  localparam int DATE = 5;
  localparam int MON  = 6;
  localparam int YR   = 7;
  localparam logic [63:0] RESET_SET = 64'h00_01_01_01_00_00_00_00;

  function automatic logic [7:0] field_mask(input logic [2:0] k);
    case (k)
      3'd0:    return 8'h3F;
      3'd1:    return 8'h7F;
      3'd2:    return 8'h7F;
      3'd3:    return 8'h3F;
      3'd4:    return 8'h07;
      3'd5:    return 8'h3F;
      3'd6:    return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  logic [7:0][7:0] ir, er, nx;
  logic            w_q, r_q, osc_q;
  logic [7:0]      last_day;
  logic            leap;

  wire [2:0] idx      = host_addr[2:0];
  wire       ctl_wr   = host_we && host_addr == 4'h8;
  wire       xfer     = ctl_wr && w_q && !host_wdata[7];
  wire       w_eff    = ctl_wr ? host_wdata[7] : w_q;
  wire       field_wr = host_we && host_addr[3] && w_eff;
  wire       step     = tick_1hz && !osc_q;

  assign leap = ir[YR][4] ? (ir[YR][3:0] == 4'h2 || ir[YR][3:0] == 4'h6)
                          : (ir[YR][3:0] == 4'h0 || ir[YR][3:0] == 4'h4 || ir[YR][3:0] == 4'h8);

  always_comb begin
    case (ir[MON])
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  always_comb begin
    nx = ir;
    if (ir[SEC] != 8'h59) nx[SEC] = bcd_inc(ir[SEC]);
    else begin
      nx[SEC] = 8'h00;
      if (ir[MIN] != 8'h59) nx[MIN] = bcd_inc(ir[MIN]);
      else begin
        nx[MIN] = 8'h00;
        if (ir[HR] != 8'h23) nx[HR] = bcd_inc(ir[HR]);
        else begin
          nx[HR]  = 8'h00;
          nx[DOW] = (ir[DOW] >= 8'h07) ? 8'h01 : ir[DOW] + 8'h01;
          if (ir[DATE] < last_day) nx[DATE] = bcd_inc(ir[DATE]);
          else begin
            nx[DATE] = 8'h01;
            if (ir[MON] < 8'h12) nx[MON] = bcd_inc(ir[MON]);
            else begin
              nx[MON] = 8'h01;
              if (ir[YR] != 8'h99) nx[YR] = bcd_inc(ir[YR]);
              else begin
                nx[YR]  = 8'h00;
                nx[CEN] = (ir[CEN] >= 8'h39) ? 8'h00 : bcd_inc(ir[CEN]);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    ir <= RESET_SET;
    else if (xfer) ir <= er;
    else if (step) ir <= nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) er <= RESET_SET;
    else begin
      if (tick_1hz && !w_q && !r_q) er <= step ? nx : ir;
      if (field_wr) er[idx] <= host_wdata & field_mask(idx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q   <= 1'b0;
      r_q   <= 1'b0;
      osc_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        w_q <= host_wdata[7];
        r_q <= host_wdata[6];
      end
      if (host_we && host_addr == 4'h9) osc_q <= host_wdata[7];
    end
  end

  always_comb begin
    case (host_addr)
      4'h8:    host_rdata = {w_q, r_q, er[CEN][5:0]};
      4'h9:    host_rdata = {osc_q, er[SEC][6:0]};
      4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF: host_rdata = er[idx];
      default: host_rdata = 8'h00;
    endcase
  end

  a_r3_idle_counters: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !xfer) |=> $stable(ir));
  a_r6_stopped_counters: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_q && !xfer) |=> $stable(ir));
  a_r7_refresh_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !w_q && !r_q && !host_we) |=> (er == ir));
  a_r8_read_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (r_q && !host_we) |=> $stable(er));
  a_r9_write_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (w_q && !host_we) |=> $stable(er));
  a_r10_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (ir == $past(er)));

endmodule

// File: tb/bcd_timekeeper_tb.sv
module bcd_timekeeper_tb;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  int mc, my, mmo, md, mdw, mh, mmi, ms;
  bit bw, br, bosc;

  bcd_timekeeper u_dut (.clk(clk), .rst_n(rst_n), .tick_1hz(tick), .host_we(we),
                        .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata));

  always #4 clk = ~clk;

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic adv();
    ms++;
    if (ms == 60) begin
      ms = 0; mmi++;
      if (mmi == 60) begin
        mmi = 0; mh++;
        if (mh == 24) begin
          mh = 0; mdw = (mdw == 7) ? 1 : mdw + 1; md++;
          if (md > dim(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin
              mmo = 1; my++;
              if (my == 100) begin my = 0; mc = (mc == 39) ? 0 : mc + 1; end
            end
          end
        end
      end
    end
  endtask

  function automatic logic [7:0] exp_byte(int k);
    case (k)
      8:  return {bw, br, bcd(mc)[5:0]};
      9:  return {bosc, bcd(ms)[6:0]};
      10: return bcd(mmi);
      11: return bcd(mh);
      12: return bcd(mdw);
      13: return bcd(md);
      14: return bcd(mmo);
      default: return bcd(my);
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic chk_all(string req);
    logic [7:0] v;
    for (int k = 8; k < 16; k++) begin
      rd(4'(k), v);
      chk(req, v, exp_byte(k));
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic load_fields(int y, int mo, int d, int dw, int h, int mi, int s);
    wr(4'h9, {bosc, bcd(s)[6:0]}); wr(4'hA, bcd(mi)); wr(4'hB, bcd(h));
    wr(4'hC, bcd(dw)); wr(4'hD, bcd(d)); wr(4'hE, bcd(mo)); wr(4'hF, bcd(y));
    my = y; mmo = mo; md = d; mdw = dw; mh = h; mmi = mi; ms = s;
  endtask

  task automatic set_time(int c, int y, int mo, int d, int dw, int h, int mi, int s);
    wr(4'h8, 8'h80 | bcd(c));
    load_fields(y, mo, d, dw, h, mi, s);
    wr(4'h8, bcd(c));
    mc = c; bw = 0; br = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mc = 0; my = 0; mmo = 1; md = 1; mdw = 1; mh = 0; mmi = 0; ms = 0;
    bw = 0; br = 0; bosc = 0;
    chk_all("R1");

    // R2: low indices inert, field widths masked
    wr(4'h3, 8'hFF); wr(4'h0, 8'h55);
    for (int k = 0; k < 8; k++) begin rd(4'(k), v); chk("R2", v, 8'h00); end
    chk_all("R2");
    wr(4'h8, 8'h80); bw = 1;
    wr(4'hC, 8'hFF); rd(4'hC, v); chk("R2", v, 8'h07);
    wr(4'hB, 8'hFF); rd(4'hB, v); chk("R2", v, 8'h3F);
    wr(4'hE, 8'hFF); rd(4'hE, v); chk("R2", v, 8'h1F);
    set_time(20, 23, 6, 15, 4, 10, 20, 30);

    // R11: writes with write hold clear leave fields alone
    wr(4'h9, 8'h45); wr(4'hA, 8'h12); wr(4'hF, 8'h77); wr(4'h8, 8'h15);
    chk_all("R11");

    // R3 and R7: consecutive run across midnight into leap day
    set_time(20, 4, 2, 28, 7, 23, 58, 30);
    for (int n = 0; n < 120; n++) begin do_tick(); adv(); chk_all("R3"); end
    set_time(20, 50, 7, 9, 3, 10, 59, 58);
    for (int n = 0; n < 4; n++) begin do_tick(); adv(); chk_all("R7"); end

    // R4 and R5: end-of-day sweep over month ends and years
    for (int yi = 0; yi < 9; yi++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        int y;
        y = (yi == 8) ? 99 : yi;
        for (int d = 28; d <= dim(mo, y); d++) begin
          set_time((y == 99) ? 39 : 20, y, mo, d, 7, 23, 59, 59);
          do_tick(); adv();
          chk_all((y == 99 && mo == 12 && d == 31) ? "R5" : "R4");
        end
      end
    end
    set_time(19, 99, 12, 31, 5, 23, 59, 59);
    do_tick(); adv(); chk_all("R5");

    // R6: stop bit
    set_time(20, 30, 5, 5, 2, 12, 0, 0);
    wr(4'h9, 8'h80); bosc = 1;
    rd(4'h9, v); chk("R6", v, 8'h80);
    repeat (3) do_tick();
    chk_all("R6");
    wr(4'h9, 8'h00); bosc = 0;
    do_tick(); adv(); chk_all("R6");

    // R8: read hold
    set_time(20, 10, 3, 31, 2, 8, 15, 59);
    wr(4'h8, 8'h40); br = 1;
    repeat (5) do_tick();
    chk_all("R8");
    wr(4'h8, 8'h00); br = 0;
    do_tick();
    repeat (6) adv();
    chk_all("R8");

    // R9: write hold freezes and accepts writes
    set_time(20, 41, 8, 20, 6, 14, 30, 10);
    wr(4'h8, 8'h80 | bcd(21)); bw = 1; mc = 21;
    repeat (3) do_tick();
    chk_all("R9");
    load_fields(42, 11, 30, 1, 23, 59, 59);
    chk_all("R9");

    // R10: transfer and pulse on the same edge; the pulse is dropped
    @(negedge clk); we = 1'b1; addr = 4'h8; wdata = bcd(21); tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0; bw = 0;
    chk_all("R10");
    do_tick(); adv(); chk_all("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule